// File: doc/BRIEF.md
# YUV to RGB Converter with Chroma Keyer

This block turns a stream of 4:4:4 YUV pixels into RGB for a video output path. Y is an 8-bit unsigned code. U and V are 8-bit codes centred on 128, and the matrix treats them as signed offsets from that centre. Three products with fixed coefficients build R, G and B. The coefficients are stored with six fractional bits: 88/64, 45/64, 22/64 and 111/64. Each sum is rounded and clamped to the unsigned 8-bit range.

Alongside the matrix, a chroma keyer compares the raw U and V codes with two programmable windows and produces a one-bit alpha. The keyer is turned off by setting the low limit of either window above its high limit. In that case alpha is forced to 1.

A two-bit format select picks the output packing: 24-bit RGB plus alpha, 15-bit RGB plus alpha in 16 bits, or a bypass that passes YUV or monochrome Y through unchanged. The limits and the format are sampled together with each pixel. Results appear two clocks after the pixel, with a matching valid flag.

Top module: `yuv_rgb_keyer`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock edges, and `out_data` carries the result of the pixel presented two edges earlier.
- R2: The red channel is clamp(floor((64·Y + 88·(V−128) + 32) / 64)).
- R3: The green channel is clamp(floor((64·Y − 45·(V−128) − 22·(U−128) + 32) / 64)).
- R4: The blue channel is clamp(floor((64·Y + 111·(U−128) + 32) / 64)).
- R5: clamp maps results below 0 to 0 and results above 255 to 255.
- R6: When keying is enabled, alpha is 1 exactly when both of these hold: `cfg_u_lo` ≤ U ≤ `cfg_u_hi`, and `cfg_v_lo` ≤ V ≤ `cfg_v_hi`. The comparison uses the raw unsigned codes and includes both limits.
- R7: Keying is disabled when `cfg_u_lo` > `cfg_u_hi` or `cfg_v_lo` > `cfg_v_hi`. While disabled, alpha is 1.
- R8: Format 0 (RGB24) packs the word as follows: bit 24 is alpha, bits 23:16 are R, bits 15:8 are G, bits 7:0 are B, and bits 31:25 are 0.
- R9: Format 1 (RGB555) packs the word as follows: bit 15 is alpha, bits 14:10 are R[7:3], bits 9:5 are G[7:3], bits 4:0 are B[7:3], and bits 31:16 are 0.
- R10: Format 2 (YUV bypass) packs the word as follows: bits 23:16 are Y, bits 15:8 are U, bits 7:0 are V, and bits 31:24 are 0.
- R11: Format 3 (monochrome) places Y in bits 7:0. All other bits are 0.
- R12: While reset is asserted, `out_valid` and `out_data` are 0.
- R13: `out_data` holds its last value on cycles that carry no valid pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel present on this cycle |
| in_y | input | 8 | Luma code |
| in_u | input | 8 | Blue-difference code, centred on 128 |
| in_v | input | 8 | Red-difference code, centred on 128 |
| cfg_fmt | input | 2 | Output format: 0 RGB24, 1 RGB555, 2 YUV, 3 mono |
| cfg_u_lo | input | 8 | Lower U key limit |
| cfg_u_hi | input | 8 | Upper U key limit |
| cfg_v_lo | input | 8 | Lower V key limit |
| cfg_v_hi | input | 8 | Upper V key limit |
| out_valid | output | 1 | Result present |
| out_data | output | 32 | Packed result word |

## Verification
The assertions check several properties on every cycle:
- the two-cycle alignment of valid;
- that the output word holds between pixels;
- that alpha is forced when a window is inverted;
- that a U code below its enabled window clears alpha;
- that the RGB555 upper half is zero;
- that the monochrome bypass is exact.

Only the bench's sweeps can show that the rounding and clamping of each matrix channel are right across the U, V and Y grid. The same holds for the inclusive boundaries of the key windows and the bit placement of every format.

// File: rtl/yuvk_pkg.sv
package yuvk_pkg;
    typedef enum logic [1:0] {
        FMT_RGB24  = 2'd0,
        FMT_RGB555 = 2'd1,
        FMT_YUV    = 2'd2,
        FMT_MONO   = 2'd3
    } fmt_e;
endpackage

// File: rtl/yuvk_matrix.sv
module yuvk_matrix #(
    parameter int DW   = 8,
    parameter int FRAC = 6,
    parameter int AW   = DW + FRAC + 3,
    parameter int K_RV = 88,
    parameter int K_GV = 45,
    parameter int K_GU = 22,
    parameter int K_BU = 111
) (
    input  logic [DW-1:0]        y_i,
    input  logic [DW-1:0]        u_i,
    input  logic [DW-1:0]        v_i,
    output logic signed [AW-1:0] acc_o [3]
);
    localparam logic signed [AW-1:0] C_RV = AW'(K_RV);
    localparam logic signed [AW-1:0] C_GV = AW'(K_GV);
    localparam logic signed [AW-1:0] C_GU = AW'(K_GU);
    localparam logic signed [AW-1:0] C_BU = AW'(K_BU);

    // offset-binary to two's complement: flip the top bit
    logic [DW-1:0]        du_raw, dv_raw;
    logic signed [AW-1:0] du, dv, ys;
    logic signed [AW-1:0] p_rv, p_gv, p_gu, p_bu;

    assign du_raw = {~u_i[DW-1], u_i[DW-2:0]};
    assign dv_raw = {~v_i[DW-1], v_i[DW-2:0]};
    assign du     = {{(AW-DW){du_raw[DW-1]}}, du_raw};
    assign dv     = {{(AW-DW){dv_raw[DW-1]}}, dv_raw};
    assign ys     = {{(AW-DW-FRAC){1'b0}}, y_i, {FRAC{1'b0}}};

    assign p_rv = dv * C_RV;
    assign p_gv = dv * C_GV;
    assign p_gu = du * C_GU;
    assign p_bu = du * C_BU;

    assign acc_o[0] = ys + p_rv;
    assign acc_o[1] = ys - p_gv - p_gu;
    assign acc_o[2] = ys + p_bu;
endmodule

// File: rtl/yuvk_keyer.sv
module yuvk_keyer #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] u_i,
    input  logic [DW-1:0] v_i,
    input  logic [DW-1:0] u_lo_i,
    input  logic [DW-1:0] u_hi_i,
    input  logic [DW-1:0] v_lo_i,
    input  logic [DW-1:0] v_hi_i,
    output logic          alpha_o
);
    logic key_on, u_in, v_in;

    assign key_on  = (u_lo_i <= u_hi_i) && (v_lo_i <= v_hi_i);
    assign u_in    = (u_i >= u_lo_i) && (u_i <= u_hi_i);
    assign v_in    = (v_i >= v_lo_i) && (v_i <= v_hi_i);
    assign alpha_o = !key_on || (u_in && v_in);
endmodule

// File: rtl/yuvk_pack.sv
module yuvk_pack
    import yuvk_pkg::*;
#(
    parameter int DW   = 8,
    parameter int FRAC = 6,
    parameter int AW   = DW + FRAC + 3,
    parameter int PW   = 5,
    parameter int OW   = 32
) (
    input  logic signed [AW-1:0] acc_i [3],
    input  logic                 alpha_i,
    input  logic [DW-1:0]        y_i,
    input  logic [DW-1:0]        u_i,
    input  logic [DW-1:0]        v_i,
    input  fmt_e                 fmt_i,
    output logic [OW-1:0]        data_o
);
    localparam logic signed [AW-1:0] HALF = AW'(1 << (FRAC - 1));
    localparam logic signed [AW-1:0] TOPV = AW'((1 << DW) - 1);

    logic [DW-1:0] ch [3];

    generate
        for (genvar i = 0; i < 3; i++) begin : g_sat
            logic signed [AW-1:0] sh;
            assign sh    = (acc_i[i] + HALF) >>> FRAC;
            assign ch[i] = sh[AW-1]  ? '0 :
                           (sh > TOPV) ? '1 : sh[DW-1:0];
        end
    endgenerate

    always_comb begin
        data_o = '0;
        unique case (fmt_i)
            FMT_RGB24: begin
                data_o[3*DW]       = alpha_i;
                data_o[3*DW-1:0]   = {ch[0], ch[1], ch[2]};
            end
            FMT_RGB555: begin
                data_o[3*PW]       = alpha_i;
                data_o[3*PW-1:0]   = {ch[0][DW-1 -: PW], ch[1][DW-1 -: PW], ch[2][DW-1 -: PW]};
            end
            FMT_YUV:  data_o[3*DW-1:0] = {y_i, u_i, v_i};
            FMT_MONO: data_o[DW-1:0]   = y_i;
            default:  data_o = '0;
        endcase
    end
endmodule

// File: rtl/yuv_rgb_keyer.sv
module yuv_rgb_keyer
    import yuvk_pkg::*;
#(
    parameter int DW   = 8,
    parameter int FRAC = 6,
    parameter int PW   = 5,
    parameter int OW   = 32,
    parameter int K_RV = 88,
    parameter int K_GV = 45,
    parameter int K_GU = 22,
    parameter int K_BU = 111
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_y,
    input  logic [DW-1:0] in_u,
    input  logic [DW-1:0] in_v,
    input  logic [1:0]    cfg_fmt,
    input  logic [DW-1:0] cfg_u_lo,
    input  logic [DW-1:0] cfg_u_hi,
    input  logic [DW-1:0] cfg_v_lo,
    input  logic [DW-1:0] cfg_v_hi,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);
    localparam int AW = DW + FRAC + 3;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] r;
        logic [AW-1:0] g;
        logic [AW-1:0] b;
        logic          alpha;
        logic [DW-1:0] y;
        logic [DW-1:0] u;
        logic [DW-1:0] v;
        fmt_e          fmt;
    } s1_t;

    typedef struct packed {
        logic          valid;
        logic [OW-1:0] data;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;

    logic signed [AW-1:0] mx_acc [3];
    logic signed [AW-1:0] s1_acc [3];
    logic                 key_alpha;
    logic [OW-1:0]        pk_data;

    yuvk_matrix #(
        .DW(DW), .FRAC(FRAC), .AW(AW),
        .K_RV(K_RV), .K_GV(K_GV), .K_GU(K_GU), .K_BU(K_BU)
    ) u_matrix (
        .y_i   (in_y),
        .u_i   (in_u),
        .v_i   (in_v),
        .acc_o (mx_acc)
    );

    yuvk_keyer #(.DW(DW)) u_keyer (
        .u_i    (in_u),
        .v_i    (in_v),
        .u_lo_i (cfg_u_lo),
        .u_hi_i (cfg_u_hi),
        .v_lo_i (cfg_v_lo),
        .v_hi_i (cfg_v_hi),
        .alpha_o(key_alpha)
    );

    assign s1_acc[0] = $signed(s1_q.r);
    assign s1_acc[1] = $signed(s1_q.g);
    assign s1_acc[2] = $signed(s1_q.b);

    yuvk_pack #(.DW(DW), .FRAC(FRAC), .AW(AW), .PW(PW), .OW(OW)) u_pack (
        .acc_i  (s1_acc),
        .alpha_i(s1_q.alpha),
        .y_i    (s1_q.y),
        .u_i    (s1_q.u),
        .v_i    (s1_q.v),
        .fmt_i  (s1_q.fmt),
        .data_o (pk_data)
    );

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = in_valid;
        if (in_valid) begin
            s1_d.r     = mx_acc[0];
            s1_d.g     = mx_acc[1];
            s1_d.b     = mx_acc[2];
            s1_d.alpha = key_alpha;
            s1_d.y     = in_y;
            s1_d.u     = in_u;
            s1_d.v     = in_v;
            s1_d.fmt   = fmt_e'(cfg_fmt);
        end
        s2_d       = s2_q;
        s2_d.valid = s1_q.valid;
        if (s1_q.valid) begin
            s2_d.data = pk_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.valid;
    assign out_data  = s2_q.data;

    // cycles since reset, saturating, so that history checks stay inside it
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R13
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_q.valid |=> $stable(out_data));

    // R7
    key_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_fmt == 2'd0 &&
         ((cfg_u_lo > cfg_u_hi) || (cfg_v_lo > cfg_v_hi))) |-> ##2 out_data[3*DW]);

    // R6
    key_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_fmt == 2'd0 && cfg_u_lo <= cfg_u_hi &&
         cfg_v_lo <= cfg_v_hi && in_u < cfg_u_lo) |-> ##2 !out_data[3*DW]);

    // R9
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_fmt == 2'd1) |-> ##2 (out_data[OW-1:3*PW+1] == '0));

    // R11
    mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_fmt == 2'd3) |-> ##2
        (out_data == {{(OW-DW){1'b0}}, $past(in_y, 2)}));
endmodule

// File: tb/yuv_rgb_keyer_bench.sv
`timescale 1ns/1ps
module yuv_rgb_keyer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
    logic [1:0]  cfg_fmt = '0;
    logic [7:0]  cfg_u_lo = '0, cfg_u_hi = 8'hff, cfg_v_lo = '0, cfg_v_hi = 8'hff;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    logic [1:0]  fmt_q [$];
    logic        koff_q [$];
    logic [2:0]  sat_q [$];
    logic        h1 = 1'b0, h2 = 1'b0;

    always #2 clk = ~clk;

    yuv_rgb_keyer u_yuv_rgb_keyer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_y(in_y), .in_u(in_u), .in_v(in_v), .cfg_fmt(cfg_fmt),
        .cfg_u_lo(cfg_u_lo), .cfg_u_hi(cfg_u_hi),
        .cfg_v_lo(cfg_v_lo), .cfg_v_hi(cfg_v_hi),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int chan(input int acc, output bit sat);
        int t;
        t = (acc + 32) >>> 6;
        sat = (t < 0) || (t > 255);
        if (t < 0) return 0;
        if (t > 255) return 255;
        return t;
    endfunction

    task automatic px(input int y, input int u, input int v, input int f);
        int du, dv, r, g, b;
        bit sr, sg, sb, koff, alpha;
        logic [31:0] w;
        du = u - 128; dv = v - 128;
        r = chan(64*y + 88*dv, sr);
        g = chan(64*y - 45*dv - 22*du, sg);
        b = chan(64*y + 111*du, sb);
        koff  = (cfg_u_lo > cfg_u_hi) || (cfg_v_lo > cfg_v_hi);
        alpha = koff || (u >= cfg_u_lo && u <= cfg_u_hi && v >= cfg_v_lo && v <= cfg_v_hi);
        w = '0;
        case (f)
            0: w = {7'd0, alpha, r[7:0], g[7:0], b[7:0]};
            1: w = {16'd0, alpha, r[7:3], g[7:3], b[7:3]};
            2: w = {8'd0, y[7:0], u[7:0], v[7:0]};
            default: w = {24'd0, y[7:0]};
        endcase
        in_y = y[7:0]; in_u = u[7:0]; in_v = v[7:0];
        cfg_fmt = f[1:0]; in_valid = 1'b1;
        exp_q.push_back(w); fmt_q.push_back(f[1:0]);
        koff_q.push_back(koff); sat_q.push_back({sr, sg, sb});
        @(negedge clk);
    endtask

    task automatic set_key(input int ulo, input int uhi, input int vlo, input int vhi);
        cfg_u_lo = ulo[7:0]; cfg_u_hi = uhi[7:0];
        cfg_v_lo = vlo[7:0]; cfg_v_hi = vhi[7:0];
    endtask

    task automatic sweep(input int f);
        int ys [5] = '{0, 40, 128, 200, 255};
        for (int yi = 0; yi < 5; yi++)
            for (int u = 0; u < 256; u += 17)
                for (int v = 0; v < 256; v += 17)
                    px(ys[yi], u, v, f);
    endtask

    always @(posedge clk) begin
        h1 <= rst_n ? in_valid : 1'b0;
        h2 <= rst_n ? h1 : 1'b0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            // R1: valid alignment
            chk("R1 valid", {31'd0, out_valid}, {31'd0, h2});
            if (out_valid && exp_q.size() > 0) begin
                logic [31:0] e;
                logic [1:0]  f;
                logic        k;
                logic [2:0]  s;
                e = exp_q.pop_front(); f = fmt_q.pop_front();
                k = koff_q.pop_front(); s = sat_q.pop_front();
                case (f)
                    2'd0: begin
                        chk(s[2] ? "R5 red" : "R2 red", {24'd0, out_data[23:16]}, {24'd0, e[23:16]});
                        chk(s[1] ? "R5 green" : "R3 green", {24'd0, out_data[15:8]}, {24'd0, e[15:8]});
                        chk(s[0] ? "R5 blue" : "R4 blue", {24'd0, out_data[7:0]}, {24'd0, e[7:0]});
                        chk(k ? "R7 alpha" : "R6 alpha", {31'd0, out_data[24]}, {31'd0, e[24]});
                        chk("R8 upper", {25'd0, out_data[31:25]}, {25'd0, e[31:25]});
                    end
                    2'd1: chk("R9 rgb555", out_data, e);
                    2'd2: chk("R10 yuv", out_data, e);
                    default: chk("R11 mono", out_data, e);
                endcase
            end
        end
    end

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 valid", {31'd0, out_valid}, 32'd0);
        chk("R12 data", out_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 directed extremes
        set_key(0, 255, 0, 255);
        px(255, 128, 255, 0);
        px(0, 0, 0, 0);
        px(128, 128, 128, 0);
        // key window with inclusive edges (R6)
        set_key(51, 153, 34, 170);
        sweep(0);
        // U window inverted (R7)
        set_key(200, 100, 34, 170);
        sweep(0);
        // V window inverted (R7)
        set_key(0, 255, 90, 89);
        sweep(0);
        // single-point window (R6)
        set_key(85, 85, 170, 170);
        sweep(0);
        set_key(51, 153, 34, 170);
        sweep(1);
        sweep(2);
        sweep(3);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R13: output holds with no valid input
        snap = out_data;
        repeat (4) @(negedge clk);
        chk("R13 hold", out_data, snap);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule